// File: doc/BRIEF.md
# UART FIFO Controller with Ready-Pin Signaling

This block holds the transmit and receive byte queues of a serial port and decides when the two active-low request pins should ask a DMA engine for service. The transmit and receive queues are each 32 entries deep. A host writes an 8-bit control word that switches queueing on or off, empties either queue on demand, picks a fill threshold for each direction and chooses between two request-pin behaviours. The serial side pushes received bytes in and pulls bytes to send out. It can also pulse a time-out input when received data has sat idle.

With queueing switched off, each direction behaves as a single-byte holding register. In the simple request mode, the receive pin asks whenever any byte is waiting and the transmit pin asks whenever its queue is empty. In the block mode, the transmit pin stays low until the queue is completely full. The receive pin latches low once the threshold is reached, or on a time-out, and it stays low until the queue drains to empty.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Each queue holds 32 bytes and returns them in arrival order. A push into a full queue is discarded and sets that queue's sticky overflow flag. The flag stays set until the queue is flushed.
- R2: A pop from an empty queue leaves the data output at the last byte popped and leaves the level at 0.
- R3: A control write with bit 0 = 0 ignores bits 7..1. It clears the whole control word, empties both queues and clears both overflow flags.
- R4: A control write with bit 0 = 1 stores bit 3 (request mode), bits 5:4 (transmit threshold code) and bits 7:6 (receive threshold code). The control readback shows those bits, bit 0 = 1 and bits 2:1 = 0.
- R5: Bit 1 = 1 in an enabled write empties the receive queue and clears its overflow flag. The transmit queue is left unchanged, and bit 1 reads back as 0.
- R6: Bit 2 = 1 in an enabled write empties the transmit queue and clears its overflow flag. The receive queue is left unchanged, and bit 2 reads back as 0.
- R7: The receive threshold codes 00, 01, 10 and 11 select 8, 16, 24 and 28 bytes. rx_trig_o is 1 while queueing is on and the receive level is at or above the threshold.
- R8: The transmit threshold codes 00, 01, 10 and 11 select 16, 8, 24 and 30 bytes. tx_trig_o is 1 while queueing is on and the transmit level is at or below the threshold.
- R9: In block mode (bit 0 = 1 and bit 3 = 1), tx_ready_no is 1 exactly when the transmit queue holds 32 bytes.
- R10: In block mode, rx_ready_no falls when the receive level reaches the threshold, or when rx_timeout_i pulses while bytes are present. It stays 0 until the level is 0.
- R11: Outside block mode, rx_ready_no is 0 whenever a received byte is present and tx_ready_no is 0 only when the transmit queue is empty.
- R12: With bit 0 = 0, each queue accepts only one byte. A second push is discarded and sets the overflow flag.
- R13: Every control effect, including the self-clearing flushes, is visible on the clock edge that samples ctrl_we_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 8 | Control word write data |
| ctrl_o | output | 8 | Control word readback |
| tx_push_i | input | 1 | Host pushes a byte to transmit |
| tx_data_i | input | 8 | Byte pushed for transmit |
| tx_pop_i | input | 1 | Serializer takes a byte |
| tx_data_o | output | 8 | Last byte taken from the transmit queue |
| tx_level_o | output | 6 | Transmit queue fill level |
| tx_ovf_o | output | 1 | Sticky transmit overflow |
| rx_push_i | input | 1 | Deserializer delivers a byte |
| rx_data_i | input | 8 | Byte delivered by the deserializer |
| rx_pop_i | input | 1 | Host reads a byte |
| rx_data_o | output | 8 | Last byte taken from the receive queue |
| rx_level_o | output | 6 | Receive queue fill level |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| rx_timeout_i | input | 1 | Receive idle time-out pulse |
| rx_trig_o | output | 1 | Receive level at or above threshold |
| tx_trig_o | output | 1 | Transmit level at or below threshold |
| rx_ready_no | output | 1 | Receive DMA request, active low |
| tx_ready_no | output | 1 | Transmit DMA request, active low |

## Verification
Internal errors in this block reach the ports within a cycle or two. A wrong pointer shows up on the next pop as a byte out of order. A wrong count appears at once on the level outputs and then on the threshold and request pins. A lost request latch is the slowest fault to expose. It shows only while the receive level lies between 1 and the threshold, so the bench walks the queue down through that range after every threshold crossing. It also checks the pin at level 1 and at level 0.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  typedef struct packed {
    logic [1:0] rx_code;
    logic [1:0] tx_code;
    logic       blk_mode;
    logic       en;
  } ufc_cfg_t;

  function automatic int rx_thresh(logic [1:0] code);
    case (code)
      2'b00:   return 8;
      2'b01:   return 16;
      2'b10:   return 24;
      default: return 28;
    endcase
  endfunction

  // tx encoding is deliberately non-monotonic
  function automatic int tx_thresh(logic [1:0] code);
    case (code)
      2'b00:   return 16;
      2'b01:   return 8;
      2'b10:   return 24;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg
  import ufc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output ufc_cfg_t   cfg_o,
  output ufc_cfg_t   cfg_nxt_o,
  output logic       rx_flush_o,
  output logic       tx_flush_o
);
  ufc_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d      = cfg_q;
    rx_flush_o = 1'b0;
    tx_flush_o = 1'b0;
    if (we_i) begin
      if (wdata_i[0]) begin
        cfg_d.en       = 1'b1;
        cfg_d.blk_mode = wdata_i[3];
        cfg_d.tx_code  = wdata_i[5:4];
        cfg_d.rx_code  = wdata_i[7:6];
        rx_flush_o     = wdata_i[1];
        tx_flush_o     = wdata_i[2];
      end else begin
        cfg_d      = '0;
        rx_flush_o = 1'b1;
        tx_flush_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign cfg_o     = cfg_q;
  assign cfg_nxt_o = cfg_d;
endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             single_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic [CW-1:0]    level_o,
  output logic [CW-1:0]    level_nxt_o,
  output logic             ovf_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [WIDTH-1:0] dout_q;
  logic             ovf_q;
  logic             full, empty, push_ok, pop_ok;

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full    = single_i ? (cnt_q != '0) : (int'(cnt_q) == DEPTH);
  assign empty   = (cnt_q == '0);
  assign push_ok = push_i & ~full;
  assign pop_ok  = pop_i & ~empty;

  always_comb begin
    if (flush_i) cnt_d = '0;
    else         cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q   <= '0;
      rd_q   <= '0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
      dout_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (push_ok) wr_q <= wrap_inc(wr_q);
      if (pop_ok) begin
        rd_q   <= wrap_inc(rd_q);
        dout_q <= mem[rd_q];
      end
      if (push_i & full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wr_q] <= data_i;
  end

  assign data_o      = dout_q;
  assign level_o     = cnt_q;
  assign level_nxt_o = cnt_d;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/ufc_ready_gen.sv
module ufc_ready_gen
  import ufc_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ufc_cfg_t      cfg_i,
  input  ufc_cfg_t      cfg_nxt_i,
  input  logic [CW-1:0] rx_level_i,
  input  logic [CW-1:0] rx_level_nxt_i,
  input  logic [CW-1:0] tx_level_i,
  input  logic          rx_timeout_i,
  output logic          rx_trig_o,
  output logic          tx_trig_o,
  output logic          rx_ready_no,
  output logic          tx_ready_no
);
  logic blk_now, blk_nxt, rx_req_q, rx_req_d, nxt_busy;

  assign blk_now  = cfg_i.en & cfg_i.blk_mode;
  assign blk_nxt  = cfg_nxt_i.en & cfg_nxt_i.blk_mode;
  assign nxt_busy = (rx_level_nxt_i != '0);

  // latch evaluated on next-state level so the pin moves with the count
  assign rx_req_d = blk_nxt &
                    ((int'(rx_level_nxt_i) >= rx_thresh(cfg_nxt_i.rx_code)) |
                     (rx_timeout_i & nxt_busy) |
                     (rx_req_q & nxt_busy));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_req_q <= 1'b0;
    else         rx_req_q <= rx_req_d;
  end

  assign rx_trig_o   = cfg_i.en & (int'(rx_level_i) >= rx_thresh(cfg_i.rx_code));
  assign tx_trig_o   = cfg_i.en & (int'(tx_level_i) <= tx_thresh(cfg_i.tx_code));
  assign rx_ready_no = blk_now ? ~rx_req_q : (rx_level_i == '0);
  assign tx_ready_no = blk_now ? (int'(tx_level_i) == DEPTH) : (tx_level_i != '0);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import ufc_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [7:0]       ctrl_wdata_i,
  output logic [7:0]       ctrl_o,
  input  logic             tx_push_i,
  input  logic [WIDTH-1:0] tx_data_i,
  input  logic             tx_pop_i,
  output logic [WIDTH-1:0] tx_data_o,
  output logic [CW-1:0]    tx_level_o,
  output logic             tx_ovf_o,
  input  logic             rx_push_i,
  input  logic [WIDTH-1:0] rx_data_i,
  input  logic             rx_pop_i,
  output logic [WIDTH-1:0] rx_data_o,
  output logic [CW-1:0]    rx_level_o,
  output logic             rx_ovf_o,
  input  logic             rx_timeout_i,
  output logic             rx_trig_o,
  output logic             tx_trig_o,
  output logic             rx_ready_no,
  output logic             tx_ready_no
);
  ufc_cfg_t      cfg, cfg_nxt;
  logic          rx_flush, tx_flush;
  logic [CW-1:0] rx_level_nxt, tx_level_nxt;

  ufc_ctrl_reg i_ctrl (
    .clk_i, .rst_ni,
    .we_i       (ctrl_we_i),
    .wdata_i    (ctrl_wdata_i),
    .cfg_o      (cfg),
    .cfg_nxt_o  (cfg_nxt),
    .rx_flush_o (rx_flush),
    .tx_flush_o (tx_flush)
  );

  ufc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i     (tx_flush),
    .single_i    (~cfg.en),
    .push_i      (tx_push_i),
    .data_i      (tx_data_i),
    .pop_i       (tx_pop_i),
    .data_o      (tx_data_o),
    .level_o     (tx_level_o),
    .level_nxt_o (tx_level_nxt),
    .ovf_o       (tx_ovf_o)
  );

  ufc_byte_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i     (rx_flush),
    .single_i    (~cfg.en),
    .push_i      (rx_push_i),
    .data_i      (rx_data_i),
    .pop_i       (rx_pop_i),
    .data_o      (rx_data_o),
    .level_o     (rx_level_o),
    .level_nxt_o (rx_level_nxt),
    .ovf_o       (rx_ovf_o)
  );

  ufc_ready_gen #(.DEPTH(DEPTH)) i_ready (
    .clk_i, .rst_ni,
    .cfg_i          (cfg),
    .cfg_nxt_i      (cfg_nxt),
    .rx_level_i     (rx_level_o),
    .rx_level_nxt_i (rx_level_nxt),
    .tx_level_i     (tx_level_o),
    .rx_timeout_i   (rx_timeout_i),
    .rx_trig_o      (rx_trig_o),
    .tx_trig_o      (tx_trig_o),
    .rx_ready_no    (rx_ready_no),
    .tx_ready_no    (tx_ready_no)
  );

  assign ctrl_o = {cfg.rx_code, cfg.tx_code, cfg.blk_mode, 2'b00, cfg.en};

  logic unused_nxt;
  assign unused_nxt = ^tx_level_nxt;
endmodule

// File: rtl/ufc_checker.sv
module ufc_checker #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [7:0]       ctrl_wdata_i,
  input logic [7:0]       ctrl_o,
  input logic             tx_push_i,
  input logic             tx_pop_i,
  input logic [CW-1:0]    tx_level_o,
  input logic             rx_push_i,
  input logic             rx_pop_i,
  input logic [WIDTH-1:0] rx_data_o,
  input logic [CW-1:0]    rx_level_o,
  input logic             rx_ovf_o,
  input logic             rx_ready_no,
  input logic             tx_ready_no
);
  logic blk;
  assign blk = ctrl_o[0] & ctrl_o[3];

  assert_disable_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && !ctrl_wdata_i[0] |=> ctrl_o == 8'h00 && rx_level_o == '0 && tx_level_o == '0);

  assert_rx_flush_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_wdata_i[0] && ctrl_wdata_i[1] |=> rx_level_o == '0 && !ctrl_o[1]);

  assert_tx_flush_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && ctrl_wdata_i[0] && ctrl_wdata_i[2] |=> tx_level_o == '0 && !ctrl_o[2]);

  assert_level_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rx_level_o) <= DEPTH && int'(tx_level_o) <= DEPTH);

  assert_no_overflow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_i && !rx_pop_i && !ctrl_we_i && int'(rx_level_o) == DEPTH |=> rx_ovf_o);

  assert_single_depth_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_o[0] |-> rx_level_o <= 1 && tx_level_o <= 1);

  assert_tx_full_pin_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk |-> tx_ready_no == (int'(tx_level_o) == DEPTH));

  assert_rx_empty_pin_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk && rx_level_o == '0 |-> rx_ready_no);

  assert_simple_pins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk |-> rx_ready_no == (rx_level_o == '0) && tx_ready_no == (tx_level_o != '0));

  assert_pop_empty_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_i && !rx_push_i && !ctrl_we_i && rx_level_o == '0 |=> $stable(rx_data_o) && rx_level_o == '0);

  logic unused_in;
  assign unused_in = tx_push_i ^ tx_pop_i;
endmodule

bind uart_fifo_ctrl ufc_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_ufc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .ctrl_o       (ctrl_o),
  .tx_push_i    (tx_push_i),
  .tx_pop_i     (tx_pop_i),
  .tx_level_o   (tx_level_o),
  .rx_push_i    (rx_push_i),
  .rx_pop_i     (rx_pop_i),
  .rx_data_o    (rx_data_o),
  .rx_level_o   (rx_level_o),
  .rx_ovf_o     (rx_ovf_o),
  .rx_ready_no  (rx_ready_no),
  .tx_ready_no  (tx_ready_no)
);

// File: tb/test_uart_fifo_ctrl.sv
module test_uart_fifo_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl;
  logic       tx_push = 1'b0, tx_pop = 1'b0, rx_push = 1'b0, rx_pop = 1'b0, rx_timeout = 1'b0;
  logic [7:0] tx_din = '0, rx_din = '0, tx_dout, rx_dout;
  logic [5:0] tx_level, rx_level;
  logic       tx_ovf, rx_ovf, rx_trig, tx_trig, rx_rdy_n, tx_rdy_n;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  uart_fifo_ctrl i_uart_fifo_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_o(ctrl),
    .tx_push_i(tx_push), .tx_data_i(tx_din), .tx_pop_i(tx_pop), .tx_data_o(tx_dout),
    .tx_level_o(tx_level), .tx_ovf_o(tx_ovf),
    .rx_push_i(rx_push), .rx_data_i(rx_din), .rx_pop_i(rx_pop), .rx_data_o(rx_dout),
    .rx_level_o(rx_level), .rx_ovf_o(rx_ovf),
    .rx_timeout_i(rx_timeout), .rx_trig_o(rx_trig), .tx_trig_o(tx_trig),
    .rx_ready_no(rx_rdy_n), .tx_ready_no(tx_rdy_n)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    ctrl_we = 1'b1; ctrl_wdata = v; step(); ctrl_we = 1'b0;
  endtask
  task automatic push_rx(logic [7:0] d);
    rx_push = 1'b1; rx_din = d; step(); rx_push = 1'b0;
  endtask
  task automatic push_tx(logic [7:0] d);
    tx_push = 1'b1; tx_din = d; step(); tx_push = 1'b0;
  endtask
  task automatic pop_rx();
    rx_pop = 1'b1; step(); rx_pop = 1'b0;
  endtask
  task automatic pop_tx();
    tx_pop = 1'b1; step(); tx_pop = 1'b0;
  endtask

  function automatic int rx_lvl(int c);
    case (c) 0: return 8; 1: return 16; 2: return 24; default: return 28; endcase
  endfunction
  function automatic int tx_lvl(int c);
    case (c) 0: return 16; 1: return 8; 2: return 24; default: return 30; endcase
  endfunction

  task automatic t_reset();
    chk("R3 reset ctrl", ctrl, 0);
    chk("R1 reset rx level", rx_level, 0);
    chk("R1 reset tx level", tx_level, 0);
    chk("R11 reset rx pin", rx_rdy_n, 1);
    chk("R11 reset tx pin", tx_rdy_n, 0);
    chk("R1 reset ovf", {tx_ovf, rx_ovf}, 0);
  endtask

  task automatic t_disabled();
    wr_ctrl(8'hCA);
    chk("R3 bits ignored without enable", ctrl, 0);
    push_rx(8'h11);
    push_rx(8'h22);
    chk("R12 single depth level", rx_level, 1);
    chk("R12 single depth ovf", rx_ovf, 1);
    pop_rx();
    chk("R12 held byte", rx_dout, 8'h11);
    wr_ctrl(8'h00);
    chk("R3 flush clears ovf", rx_ovf, 0);
  endtask

  task automatic t_program();
    wr_ctrl(8'hFF);
    chk("R4 R13 readback after write edge", ctrl, 8'hF9);
    wr_ctrl(8'h59);
    chk("R4 readback pattern", ctrl, 8'h59);
  endtask

  task automatic t_order();
    wr_ctrl(8'h07);
    chk("R11 tx pin empty", tx_rdy_n, 0);
    for (int i = 0; i < 32; i++) push_tx(8'(i * 3 + 1));
    chk("R1 full level", tx_level, 32);
    chk("R11 tx pin nonempty", tx_rdy_n, 1);
    push_tx(8'hEE);
    chk("R1 push to full dropped", tx_level, 32);
    chk("R1 overflow sticky", tx_ovf, 1);
    for (int i = 0; i < 32; i++) begin
      pop_tx();
      chk("R1 order", tx_dout, (i * 3 + 1) & 8'hFF);
    end
    chk("R1 drained", tx_level, 0);
    chk("R1 ovf stays set", tx_ovf, 1);
  endtask

  task automatic t_pop_empty();
    pop_tx();
    chk("R2 data held", tx_dout, 94);
    chk("R2 level held", tx_level, 0);
  endtask

  task automatic t_resets();
    for (int i = 0; i < 3; i++) push_rx(8'(i));
    for (int i = 0; i < 5; i++) push_tx(8'(i));
    chk("R11 rx pin present", rx_rdy_n, 0);
    wr_ctrl(8'h05);
    chk("R6 tx emptied", tx_level, 0);
    chk("R6 tx ovf cleared", tx_ovf, 0);
    chk("R6 rx untouched", rx_level, 3);
    chk("R6 bit self-clears", ctrl, 8'h01);
    wr_ctrl(8'h03);
    chk("R5 rx emptied", rx_level, 0);
    chk("R5 bit self-clears", ctrl, 8'h01);
  endtask

  task automatic t_rx_thresh();
    for (int c = 0; c < 4; c++) begin
      int t = rx_lvl(c);
      wr_ctrl(8'((c << 6) | 8'h0B));
      for (int k = 1; k <= t; k++) begin
        push_rx(8'(k));
        if (k == t - 1) begin
          chk("R10 pin high below threshold", rx_rdy_n, 1);
          chk("R7 trig below threshold", rx_trig, 0);
        end
      end
      chk("R10 pin low at threshold", rx_rdy_n, 0);
      chk("R7 trig at threshold", rx_trig, 1);
      for (int k = t; k > 1; k--) pop_rx();
      chk("R10 hysteresis at level 1", rx_rdy_n, 0);
      chk("R7 trig off at level 1", rx_trig, 0);
      pop_rx();
      chk("R10 release at empty", rx_rdy_n, 1);
    end
  endtask

  task automatic t_timeout();
    wr_ctrl(8'h0B);
    rx_timeout = 1'b1; step(); rx_timeout = 1'b0;
    chk("R10 timeout on empty ignored", rx_rdy_n, 1);
    push_rx(8'hA5);
    chk("R10 one byte no request", rx_rdy_n, 1);
    rx_timeout = 1'b1; step(); rx_timeout = 1'b0;
    chk("R10 timeout request", rx_rdy_n, 0);
    push_rx(8'h5A);
    pop_rx();
    chk("R10 timeout request held", rx_rdy_n, 0);
    pop_rx();
    chk("R10 timeout request released", rx_rdy_n, 1);
  endtask

  task automatic t_tx_thresh();
    for (int c = 0; c < 4; c++) begin
      int t = tx_lvl(c);
      wr_ctrl(8'((c << 4) | 8'h0D));
      for (int k = 0; k < t; k++) push_tx(8'(k));
      chk("R8 trig at threshold", tx_trig, 1);
      push_tx(8'hFF);
      chk("R8 trig above threshold", tx_trig, 0);
    end
    while (tx_level < 31) push_tx(8'h00);
    chk("R9 pin at 31", tx_rdy_n, 0);
    push_tx(8'h00);
    chk("R9 pin at full", tx_rdy_n, 1);
    pop_tx();
    chk("R9 pin one free", tx_rdy_n, 0);
  endtask

  task automatic t_disable_flush();
    push_rx(8'h77);
    wr_ctrl(8'h00);
    chk("R3 ctrl cleared", ctrl, 0);
    chk("R3 tx flushed", tx_level, 0);
    chk("R3 rx flushed", rx_level, 0);
    chk("R11 pins after disable", {rx_rdy_n, tx_rdy_n}, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_program();
    t_order();
    t_pop_empty();
    t_resets();
    t_rx_thresh();
    t_timeout();
    t_tx_thresh();
    t_disable_flush();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule